// File: doc/BRIEF.md
# Station Address Table Loader and Receive Address Filter

This block keeps a table of sixteen 48-bit station addresses together with a 16-bit mask that says which of them are live. A load command walks a descriptor list in memory through a one-outstanding word-read port. Each descriptor names a table slot and gives the three address words for that slot. Once the descriptor count runs out, the block fetches one more word, and that word becomes the new enable mask.

For each incoming frame, the upstream parser presents the 48-bit destination address and three receive-mode flags. One cycle later the block returns a registered decision: accept or reject, plus a packet-type code. The special modes are tried first and in a fixed order: promiscuous, then all-multicast, then broadcast. Only after those does the block fall back to an exact match against the enabled table slots, and it compares all slots in parallel.

Top module: `station_filter`

## Requirements
- R1: After reset, `load_busy`, `load_done`, `rd_req` and `flt_valid` are low and the enable mask is all zero, so a unicast frame with all mode flags clear is rejected.
- R2: A descriptor is four consecutive words. Word 0 carries the slot index in its low 4 bits and its upper bits are ignored. Words 1, 2 and 3 are the address. Word 1 holds destination bytes 0 and 1, with the first byte on the wire in bits 15:8, so `frm_dest[47:40]` is the first byte.
- R3: A load processes as many descriptors as `list_count` holds (5 bits). A count of zero performs only the mask read.
- R4: In narrow mode (`load_wide`=0), consecutive words of a descriptor are 2 bytes apart and descriptors are 8 bytes apart. In wide mode they are 4 and 16 bytes apart.
- R5: After the last descriptor, exactly one more read is made at the advanced pointer, and its 16 bits become the enable mask. Bit i enables slot i.
- R6: `load_busy` rises in the cycle after a `load_start` pulse seen while idle. `load_start` is ignored while busy. `load_done` pulses for one cycle, in the cycle in which `load_busy` falls.
- R7: With `rx_mode[0]` (promiscuous) set, a frame whose first destination byte has bit 0 clear is accepted with type 0x0000.
- R8: With `rx_mode[1]` (all-multicast) set, a frame whose first destination byte has bit 0 set is accepted with type 0x0100.
- R9: With `rx_mode[2]` (broadcast) set, an all-ones destination is accepted with type 0x0080, unless all-multicast is also set, in which case it takes type 0x0100.
- R10: Otherwise a frame is accepted with type 0x0000 only if some enabled slot equals all 48 destination bits. Disabled slots never match, and a rejected frame reports type 0x0000.
- R11: `flt_valid` is high exactly in the cycle after `frm_valid` was high, one result per frame.
- R12: A later load that writes a slot again replaces its address, and each load replaces the whole enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | One-cycle pulse that starts a table load |
| load_wide | input | 1 | 1 selects 32-bit memory word spacing for this load |
| list_ptr | input | 32 | Byte address of the first descriptor |
| list_count | input | 5 | Number of descriptors to load |
| load_busy | output | 1 | A load is in progress |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| rd_req | output | 1 | Memory word read requested, held until answered |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read response, only while `rd_req` is high |
| rd_data | input | 16 | Read response data |
| frm_valid | input | 1 | Destination address presented |
| frm_dest | input | 48 | Destination address, first wire byte in bits 47:40 |
| rx_mode | input | 3 | Bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast |
| flt_valid | output | 1 | Decision valid |
| flt_accept | output | 1 | Frame accepted |
| flt_type | output | 16 | 0x0000 plain, 0x0100 multicast, 0x0080 broadcast |

## Verification
The bench targets four areas.

- **Byte order.** It presents a loaded address with its words swapped. A design that packed the bytes in the wrong order would accept that frame.
- **Load bookkeeping.** A count of zero must produce only the mask read. A design that still fetched a descriptor would show extra reads and a mask taken from the wrong address. The bench also pulses a second start in the middle of a load; a design that accepted it would restart, change the read count and move the mask address.
- **Wide spacing and rewrites.** A wide-mode load checks the 4-byte word spacing and the 16-byte descriptor spacing. A rewrite of a slot checks that the old address stops matching.
- **Filter priority.** A broadcast frame sent with all-multicast also enabled must report the multicast type, and a multicast frame in promiscuous-only mode must be rejected. A design with the filter order reversed would report the broadcast type or accept that frame.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int WORD_W = 16;
  localparam int MAC_W  = 48;

  localparam logic [WORD_W-1:0] TYPE_PLAIN = 16'h0000;
  localparam logic [WORD_W-1:0] TYPE_MCAST = 16'h0100;
  localparam logic [WORD_W-1:0] TYPE_BCAST = 16'h0080;

  localparam int MODE_PROMISC = 0;
  localparam int MODE_ALLMC   = 1;
  localparam int MODE_BCAST   = 2;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_SEL,
    LD_HI,
    LD_MID,
    LD_LO,
    LD_MASK
  } ld_state_e;
endpackage

// File: rtl/sf_loader.sv
module sf_loader
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              load_wide,
  input  logic [ADDR_W-1:0] list_ptr,
  input  logic [CNT_W-1:0]  list_count,
  output logic              load_busy,
  output logic              load_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              ent_we,
  output logic [IDX_W-1:0]  ent_idx,
  output logic [MAC_W-1:0]  ent_word,
  output logic              mask_we,
  output logic [ENTRIES-1:0] mask_word
);
  localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(16);

  ld_state_e             state_q;
  logic [ADDR_W-1:0]     ptr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  wide_q;
  logic [IDX_W-1:0]      idx_q;
  logic [WORD_W-1:0]     hi_q;
  logic [WORD_W-1:0]     mid_q;
  logic                  done_q;
  logic [1:0]            word_ofs;
  logic [ADDR_W-1:0]     byte_ofs;

  always_comb begin
    unique case (state_q)
      LD_HI:   word_ofs = 2'd1;
      LD_MID:  word_ofs = 2'd2;
      LD_LO:   word_ofs = 2'd3;
      default: word_ofs = 2'd0;
    endcase
    byte_ofs = wide_q ? {{(ADDR_W-4){1'b0}}, word_ofs, 2'b00}
                      : {{(ADDR_W-3){1'b0}}, word_ofs, 1'b0};
  end

  assign rd_req    = (state_q != LD_IDLE);
  assign rd_addr   = ptr_q + byte_ofs;
  assign load_busy = (state_q != LD_IDLE);
  assign load_done = done_q;

  // Table strobes are taken straight from the response so the table is
  // current in the same cycle the loader returns to idle.
  assign ent_we    = (state_q == LD_LO) && rd_valid;
  assign ent_idx   = idx_q;
  assign ent_word  = {hi_q, mid_q, rd_data};
  assign mask_we   = (state_q == LD_MASK) && rd_valid;
  assign mask_word = rd_data[ENTRIES-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
      idx_q   <= '0;
      hi_q    <= '0;
      mid_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        LD_IDLE: if (load_start) begin
          ptr_q   <= list_ptr;
          cnt_q   <= list_count;
          wide_q  <= load_wide;
          state_q <= (list_count != '0) ? LD_SEL : LD_MASK;
        end
        LD_SEL: if (rd_valid) begin
          idx_q   <= rd_data[IDX_W-1:0];
          state_q <= LD_HI;
        end
        LD_HI: if (rd_valid) begin
          hi_q    <= rd_data;
          state_q <= LD_MID;
        end
        LD_MID: if (rd_valid) begin
          mid_q   <= rd_data;
          state_q <= LD_LO;
        end
        LD_LO: if (rd_valid) begin
          cnt_q   <= cnt_q - CNT_W'(1);
          ptr_q   <= ptr_q + (wide_q ? STEP_WIDE : STEP_NARROW);
          state_q <= (cnt_q != CNT_W'(1)) ? LD_SEL : LD_MASK;
        end
        LD_MASK: if (rd_valid) begin
          state_q <= LD_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sf_table.sv
module sf_table
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ent_we,
  input  logic [IDX_W-1:0]   ent_idx,
  input  logic [MAC_W-1:0]   ent_word,
  input  logic               mask_we,
  input  logic [ENTRIES-1:0] mask_word,
  input  logic [MAC_W-1:0]   probe,
  output logic [ENTRIES-1:0] hit
);
  logic [MAC_W-1:0]   slot_q [ENTRIES];
  logic [ENTRIES-1:0] en_q;

  // Address storage carries no reset: the zeroed enable mask hides it.
  always_ff @(posedge clk) begin
    if (ent_we) slot_q[ent_idx] <= ent_word;
  end

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (mask_we) en_q <= mask_word;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = en_q[i] && (slot_q[i] == probe);
  end
endmodule

// File: rtl/sf_decide.sv
module sf_decide
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_valid,
  input  logic [MAC_W-1:0]   frm_dest,
  input  logic [2:0]         rx_mode,
  input  logic [ENTRIES-1:0] hit,
  output logic               flt_valid,
  output logic               flt_accept,
  output logic [WORD_W-1:0]  flt_type
);
  logic              is_group;
  logic              is_all_ones;
  logic              acc_d;
  logic [WORD_W-1:0] type_d;

  assign is_group    = frm_dest[MAC_W-8];
  assign is_all_ones = &frm_dest;

  always_comb begin
    acc_d  = 1'b0;
    type_d = TYPE_PLAIN;
    if (rx_mode[MODE_PROMISC] && !is_group) begin
      acc_d = 1'b1;
    end else if (rx_mode[MODE_ALLMC] && is_group) begin
      acc_d  = 1'b1;
      type_d = TYPE_MCAST;
    end else if (rx_mode[MODE_BCAST] && is_all_ones) begin
      acc_d  = 1'b1;
      type_d = TYPE_BCAST;
    end else begin
      acc_d = |hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid  <= 1'b0;
      flt_accept <= 1'b0;
      flt_type   <= TYPE_PLAIN;
    end else begin
      flt_valid  <= frm_valid;
      flt_accept <= frm_valid && acc_d;
      flt_type   <= frm_valid ? type_d : TYPE_PLAIN;
    end
  end
endmodule

// File: rtl/station_filter.sv
module station_filter
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              load_wide,
  input  logic [ADDR_W-1:0] list_ptr,
  input  logic [CNT_W-1:0]  list_count,
  output logic              load_busy,
  output logic              load_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [15:0]       rd_data,
  input  logic              frm_valid,
  input  logic [47:0]       frm_dest,
  input  logic [2:0]        rx_mode,
  output logic              flt_valid,
  output logic              flt_accept,
  output logic [15:0]       flt_type
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               ent_we;
  logic [IDX_W-1:0]   ent_idx;
  logic [MAC_W-1:0]   ent_word;
  logic               mask_we;
  logic [ENTRIES-1:0] mask_word;
  logic [ENTRIES-1:0] hit;

  sf_loader #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_loader (
    .clk(clk), .rst(rst),
    .load_start(load_start), .load_wide(load_wide),
    .list_ptr(list_ptr), .list_count(list_count),
    .load_busy(load_busy), .load_done(load_done),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_word(ent_word),
    .mask_we(mask_we), .mask_word(mask_word)
  );

  sf_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_word(ent_word),
    .mask_we(mask_we), .mask_word(mask_word),
    .probe(frm_dest), .hit(hit)
  );

  sf_decide #(.ENTRIES(ENTRIES)) u_decide (
    .clk(clk), .rst(rst),
    .frm_valid(frm_valid), .frm_dest(frm_dest), .rx_mode(rx_mode),
    .hit(hit),
    .flt_valid(flt_valid), .flt_accept(flt_accept), .flt_type(flt_type)
  );
endmodule

// File: rtl/sf_chk.sv
module sf_chk (
  input logic        clk,
  input logic        rst,
  input logic        load_start,
  input logic        load_busy,
  input logic        load_done,
  input logic        rd_req,
  input logic        frm_valid,
  input logic [47:0] frm_dest,
  input logic [2:0]  rx_mode,
  input logic        flt_valid,
  input logic        flt_accept,
  input logic [15:0] flt_type
);
  // R11
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> flt_valid);

  // R11
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !flt_valid);

  // R10
  reject_plain_type_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !flt_accept) |-> (flt_type == 16'h0000));

  // R8
  mcast_type_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_type == 16'h0100) |-> ($past(frm_dest[40]) && $past(rx_mode[1])));

  // R9
  bcast_type_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_type == 16'h0080) |-> ($past(&frm_dest) && $past(rx_mode[2])));

  // R6
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_busy) |-> $past(load_start));

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (!load_busy && $past(load_busy)));

  // R5
  req_inside_load_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> load_busy);
endmodule

bind station_filter sf_chk u_chk (
  .clk(clk), .rst(rst), .load_start(load_start), .load_busy(load_busy),
  .load_done(load_done), .rd_req(rd_req), .frm_valid(frm_valid),
  .frm_dest(frm_dest), .rx_mode(rx_mode), .flt_valid(flt_valid),
  .flt_accept(flt_accept), .flt_type(flt_type)
);

// File: tb/station_filter_tb.sv
module station_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_start = 1'b0;
  logic        load_wide = 1'b0;
  logic [31:0] list_ptr = '0;
  logic [4:0]  list_count = '0;
  logic        load_busy, load_done, rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dest = '0;
  logic [2:0]  rx_mode = '0;
  logic        flt_valid, flt_accept;
  logic [15:0] flt_type;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  int wait_cnt = 0;
  logic [15:0] mem [0:511];
  logic [31:0] rd_log [$];
  logic [16:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  station_filter u_dut (
    .clk(clk), .rst(rst), .load_start(load_start), .load_wide(load_wide),
    .list_ptr(list_ptr), .list_count(list_count), .load_busy(load_busy),
    .load_done(load_done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .frm_valid(frm_valid),
    .frm_dest(frm_dest), .rx_mode(rx_mode), .flt_valid(flt_valid),
    .flt_accept(flt_accept), .flt_type(flt_type)
  );

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers each request after a latency that alternates.
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
    end else if (rd_req) begin
      if (wait_cnt == 0) begin
        rd_valid = 1'b1;
        rd_data  = mem[rd_addr[9:1]];
        rd_log.push_back(rd_addr);
        wait_cnt = (rd_log.size() % 2 == 1) ? 2 : 0;
      end else begin
        wait_cnt--;
      end
    end
  end

  always @(negedge clk) if (load_done) done_cnt++;

  // Scoreboard monitor for filter results (R11 one result per frame).
  always @(negedge clk) begin
    if (flt_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R11 unexpected result actual=%0d expected=none", flt_accept);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {31'd0, flt_accept, flt_type}, {31'd0, e});
      end
    end
  end

  task automatic put(int base, int k, bit wide, logic [15:0] v);
    mem[(base + k * (wide ? 4 : 2)) >> 1] = v;
  endtask

  task automatic put_desc(int base, int n, bit wide, logic [15:0] sel, logic [47:0] a);
    int d = base + n * (wide ? 16 : 8);
    put(d, 0, wide, sel);
    put(d, 1, wide, a[47:32]);
    put(d, 2, wide, a[31:16]);
    put(d, 3, wide, a[15:0]);
  endtask

  task automatic send(logic [47:0] d, logic [2:0] m, bit acc, logic [15:0] ty, string tag);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_dest  = d;
    rx_mode   = m;
    exp_q.push_back({acc, ty});
    tag_q.push_back(tag);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic do_load(logic [31:0] p, logic [4:0] c, bit w, bit poke,
                         int exp_reads, logic [31:0] exp_second, logic [31:0] exp_last);
    int n0 = rd_log.size();
    int d0 = done_cnt;
    @(negedge clk);
    load_start = 1'b1; list_ptr = p; list_count = c; load_wide = w;
    @(negedge clk);
    load_start = 1'b0;
    chk("R6 busy after start", {47'd0, load_busy}, 48'd1);
    if (poke) begin
      load_start = 1'b1; list_ptr = 32'h180; list_count = 5'd0;
      @(negedge clk);
      load_start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 single done pulse", 48'(done_cnt - d0), 48'd1);
    chk("R6 idle after load", {47'd0, load_busy}, 48'd0);
    chk("R3 read count", 48'(rd_log.size() - n0), 48'(exp_reads));
    if (exp_reads > 1)
      chk("R4 word spacing", {16'd0, rd_log[n0 + 1]}, {16'd0, exp_second});
    chk("R5 mask read address", {16'd0, rd_log[rd_log.size() - 1]}, {16'd0, exp_last});
  endtask

  localparam logic [47:0] A = 48'h0200_1122_3344;
  localparam logic [47:0] B = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] C = 48'h0050_6070_8090;
  localparam logic [47:0] E = 48'h0600_AAAA_5555;
  localparam logic [47:0] D = 48'h1234_5678_9ABC;
  localparam logic [47:0] M = 48'h0100_5E00_0001;
  localparam logic [47:0] F = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    put_desc(32'h40, 0, 1'b0, 16'h0002, A);
    put_desc(32'h40, 1, 1'b0, 16'h0005, B);
    put_desc(32'h40, 2, 1'b0, 16'hABC3, C);
    put(32'h58, 0, 1'b0, 16'h0024);
    put_desc(32'h100, 0, 1'b1, 16'h0002, E);
    put(32'h110, 0, 1'b1, 16'h0004);
    put(32'h180, 0, 1'b0, 16'h0020);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy at reset", {47'd0, load_busy}, 48'd0);
    chk("R1 done at reset", {47'd0, load_done}, 48'd0);
    chk("R1 req at reset", {47'd0, rd_req}, 48'd0);
    chk("R1 result idle at reset", {47'd0, flt_valid}, 48'd0);
    send(A, 3'b000, 1'b0, 16'h0000, "R1 empty table rejects");

    // R2 R3: three descriptors, index upper bits ignored, mid-load start ignored
    do_load(32'h40, 5'd3, 1'b0, 1'b1, 13, 32'h42, 32'h58);
    send(A, 3'b000, 1'b1, 16'h0000, "R10 enabled slot 2 match");
    send(B, 3'b000, 1'b1, 16'h0000, "R10 enabled slot 5 match");
    send(C, 3'b000, 1'b0, 16'h0000, "R2 R10 slot 3 disabled");
    send(A ^ 48'h1, 3'b000, 1'b0, 16'h0000, "R10 one bit off rejected");
    send(48'h3344_1122_0200, 3'b000, 1'b0, 16'h0000, "R2 word order");
    send(D, 3'b000, 1'b0, 16'h0000, "R10 unknown unicast");

    send(D, 3'b001, 1'b1, 16'h0000, "R7 promiscuous unicast");
    send(M, 3'b001, 1'b0, 16'h0000, "R7 promiscuous leaves multicast");
    send(M, 3'b010, 1'b1, 16'h0100, "R8 all multicast");
    send(D, 3'b010, 1'b0, 16'h0000, "R8 unicast not affected");
    send(F, 3'b100, 1'b1, 16'h0080, "R9 broadcast");
    send(F, 3'b110, 1'b1, 16'h0100, "R9 multicast wins over broadcast");
    send(F, 3'b000, 1'b0, 16'h0000, "R9 broadcast disabled");
    send(A, 3'b111, 1'b1, 16'h0000, "R7 promiscuous on table address");

    // R4 R12: wide load rewrites slot 2, mask now only slot 2
    do_load(32'h100, 5'd1, 1'b1, 1'b0, 5, 32'h104, 32'h110);
    send(E, 3'b000, 1'b1, 16'h0000, "R12 rewritten slot matches");
    send(A, 3'b000, 1'b0, 16'h0000, "R12 old address gone");
    send(B, 3'b000, 1'b0, 16'h0000, "R12 mask replaced");

    // R3 R5: zero count, only the mask read
    do_load(32'h180, 5'd0, 1'b0, 1'b0, 1, 32'h0, 32'h180);
    send(B, 3'b000, 1'b1, 16'h0000, "R5 mask re-enables slot 5");
    send(E, 3'b000, 1'b0, 16'h0000, "R5 slot 2 disabled");

    repeat (4) @(negedge clk);
    chk("R11 all results seen", 48'(exp_q.size()), 48'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule